// File: doc/BRIEF.md
# Auto-Masking Prioritized Interrupt Controller

This block gathers level-sensitive hardware interrupt lines and per-CPU inter-processor interrupts, and presents each CPU with one interrupt output and one event register. Each source is qualified by a single global enable, which is a mask bit. A per-line software trigger is ORed into the line. A per-line routing mask chooses which CPUs may take the line. Each CPU has a "self" and an "other" IPI, and the two differ only in name.

A CPU services interrupts by reading its event register. The value carries a type in bits [17:16] (0 none, 1 hardware line, 2 IPI) and a number in bits [15:0]. For an IPI the number is 0 for self and 1 for other. The read also masks the reported source at the same clock edge. A handler therefore never writes a priority level or a separate acknowledge. It re-enables a source with a mask-clear write once the source is serviced.

Register map:
- Bit 7 of `addr` selects the view. Bit 7 low is the view of the accessing CPU, `cpu_id`. Bit 7 high is an explicit view, with the CPU index in bits [6:4].
- Low nibble 0 is the event register (read).
- Low nibble 1 is a self-IPI set (write bit 0).
- Low nibble 2 is an IPI send. Write bit c to set the "other" IPI of CPU c.
- Low nibbles 3 and 4 are the IPI mask set and the IPI mask clear (bit 0 self, bit 1 other). A read of either returns the mask in [1:0] and the pending bits in [5:4].
- Low nibbles 8 and 9 are the line mask set and the line mask clear. A read of either returns the mask.
- Low nibbles 10 and 11 are the software trigger set and the software trigger clear. A read of either returns the trigger bits.
- Addresses 0x40+i, in the default view only, are the routing mask of line i.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset all line mask bits are 1, software triggers are 0, routing masks are all-ones, IPIs are clear and enabled, every `irq_out` bit is 0, and an event read returns 0.
- R2: `irq_out[c]` is 1 when some line i has (`hw_irq[i]` OR software trigger i) AND NOT mask i AND routing bit c, or when CPU c has an enabled pending IPI. It follows such a change exactly one clock later.
- R3: A mask-set write of 1s disables lines and a mask-clear write of 1s enables them. Neither the software trigger state nor the sensed level is altered by masking.
- R4: The event register reports the lowest-numbered eligible hardware line. If no hardware line is eligible it reports the self IPI, then the other IPI.
- R5: An event read that reports hardware line n sets mask bit n at the same edge, so a second CPU routed to n sees the next source instead.
- R6: An event read with nothing eligible returns 0 and changes no state.
- R7: A line whose routing bit for CPU c is 0 is never reported to or signalled on CPU c. The routing mask reads back as written.
- R8: An "other" IPI sent to a CPU stays pending until that CPU's event read reports it. That read clears it and sets its IPI mask bit. A resend while masked stays pending without asserting `irq_out` until an IPI mask-clear write.
- R9: A self-IPI write sets the self IPI of the CPU addressed by the view.
- R10: The default view addresses CPU `cpu_id`, and the explicit view addresses the CPU in `addr[6:4]`, whatever `cpu_id` is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hw_irq | input | NUM_IRQ | Level-sensitive hardware lines |
| cpu_id | input | CPU_W | CPU making the current access |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | AW | Register address |
| wdata | input | DW | Write data |
| rdata | output | DW | Read data, valid the cycle after `rd_en` |
| irq_out | output | NUM_CPU | Per-CPU interrupt request |

## Verification
The bench gives one line to both CPUs and lets each CPU read once. A design that did not mask on the read would report the same line twice, and one with the wrong priority would return the higher number first. It also checks that a masked line keeps its software trigger and its sensed level: a design that cleared them on masking would stay silent after the unmask. IPIs are sent, read through the explicit view and resent while masked. A design that failed to mask on the read would raise `irq_out` again, and one that decoded the view from `cpu_id` would read the wrong CPU. Empty reads and routed-away lines are also checked: a design with side effects or a leaky routing mask would change the mask readback or report an event to the wrong CPU.

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl #(
  parameter int NUM_IRQ = 16,
  parameter int NUM_CPU = 2,
  parameter int AW      = 8,
  parameter int DW      = 32,
  localparam int CPU_W  = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1,
  localparam int IW     = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_IRQ-1:0] hw_irq,
  input  logic [CPU_W-1:0]   cpu_id,
  input  logic               wr_en,
  input  logic               rd_en,
  input  logic [AW-1:0]      addr,
  input  logic [DW-1:0]      wdata,
  output logic [DW-1:0]      rdata,
  output logic [NUM_CPU-1:0] irq_out
);

  logic [NUM_IRQ-1:0] irq_mask, sw_trig;
  logic [NUM_CPU-1:0] irq_route [NUM_IRQ];
  logic [1:0]         ipi_pend  [NUM_CPU];
  logic [1:0]         ipi_mask  [NUM_CPU];

  wire [3:0]       off     = addr[3:0];
  wire             in_rt   = !addr[AW-1] && addr[AW-2];
  wire [CPU_W-1:0] vcpu    = addr[AW-1] ? addr[CPU_W+3:4] : cpu_id;
  wire             vok     = int'(vcpu) < NUM_CPU;
  wire [IW-1:0]    ridx    = addr[IW-1:0];
  wire             ridx_ok = int'(addr[5:0]) < NUM_IRQ;
  wire             rd_ev   = rd_en && !in_rt && off == 4'd0 && vok;
  wire [NUM_IRQ-1:0] level = hw_irq | sw_trig;

  logic [1:0]         ev_type [NUM_CPU];
  logic [15:0]        ev_num  [NUM_CPU];
  logic [NUM_CPU-1:0] any_cand;

  always_comb begin
    for (int c = 0; c < NUM_CPU; c++) begin
      ev_type[c] = 2'd0;
      ev_num[c]  = 16'd0;
      if (ipi_pend[c][1] && !ipi_mask[c][1]) begin
        ev_type[c] = 2'd2;
        ev_num[c]  = 16'd1;
      end
      if (ipi_pend[c][0] && !ipi_mask[c][0]) begin
        ev_type[c] = 2'd2;
        ev_num[c]  = 16'd0;
      end
      for (int i = NUM_IRQ - 1; i >= 0; i--) begin
        if (level[i] && !irq_mask[i] && irq_route[i][c]) begin
          ev_type[c] = 2'd1;
          ev_num[c]  = 16'(i);
        end
      end
      any_cand[c] = ev_type[c] != 2'd0;
    end
  end

  logic [DW-1:0] rd_val;
  always_comb begin
    rd_val = '0;
    if (in_rt) begin
      if (ridx_ok) rd_val[NUM_CPU-1:0] = irq_route[ridx];
    end else begin
      case (off)
        4'd0:       if (vok) begin
                      rd_val[17:16] = ev_type[vcpu];
                      rd_val[15:0]  = ev_num[vcpu];
                    end
        4'd3, 4'd4: if (vok) begin
                      rd_val[5:4] = ipi_pend[vcpu];
                      rd_val[1:0] = ipi_mask[vcpu];
                    end
        4'd8, 4'd9:   rd_val[NUM_IRQ-1:0] = irq_mask;
        4'd10, 4'd11: rd_val[NUM_IRQ-1:0] = sw_trig;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_mask <= '1;
      sw_trig  <= '0;
      for (int i = 0; i < NUM_IRQ; i++) irq_route[i] <= '1;
      for (int c = 0; c < NUM_CPU; c++) begin
        ipi_pend[c] <= 2'b00;
        ipi_mask[c] <= 2'b00;
      end
      rdata   <= '0;
      irq_out <= '0;
    end else begin
      irq_out <= any_cand;
      if (wr_en) begin
        if (in_rt) begin
          if (ridx_ok) irq_route[ridx] <= wdata[NUM_CPU-1:0];
        end else begin
          case (off)
            4'd1:  if (vok && wdata[0]) ipi_pend[vcpu][0] <= 1'b1;
            4'd2:  for (int c = 0; c < NUM_CPU; c++)
                     if (wdata[c]) ipi_pend[c][1] <= 1'b1;
            4'd3:  if (vok) ipi_mask[vcpu] <= ipi_mask[vcpu] | wdata[1:0];
            4'd4:  if (vok) ipi_mask[vcpu] <= ipi_mask[vcpu] & ~wdata[1:0];
            4'd8:  irq_mask <= irq_mask | wdata[NUM_IRQ-1:0];
            4'd9:  irq_mask <= irq_mask & ~wdata[NUM_IRQ-1:0];
            4'd10: sw_trig  <= sw_trig | wdata[NUM_IRQ-1:0];
            4'd11: sw_trig  <= sw_trig & ~wdata[NUM_IRQ-1:0];
            default: ;
          endcase
        end
      end
      if (rd_en) begin
        rdata <= rd_val;
        if (rd_ev) begin
          if (ev_type[vcpu] == 2'd1) begin
            irq_mask[ev_num[vcpu][IW-1:0]] <= 1'b1;
          end else if (ev_type[vcpu] == 2'd2) begin
            ipi_pend[vcpu][ev_num[vcpu][0]] <= 1'b0;
            ipi_mask[vcpu][ev_num[vcpu][0]] <= 1'b1;
          end
        end
      end
    end
  end

  // R6
  empty_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ev && !wr_en && !any_cand[vcpu] |=> rdata == '0 && $stable(irq_mask));

  // R5
  hw_automask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ev && !wr_en && ev_type[vcpu] == 2'd1 |=> irq_mask[$past(ev_num[vcpu][IW-1:0])]);

  // R4
  event_field_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ev |=> rdata[17:16] != 2'd3 && (rdata[17:16] != 2'd1 || rdata[15:0] < 16'(NUM_IRQ)));

  generate
    for (genvar g = 0; g < NUM_CPU; g++) begin : g_ipi_chk
      // R8
      ipi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ipi_pend[g][1]) |-> $past(rd_ev && int'(vcpu) == g));
    end
  endgenerate

endmodule

// File: tb/test_prio_irq_ctrl.sv
`timescale 1ns/1ps
module test_prio_irq_ctrl;

  localparam int NUM_IRQ = 16;
  localparam int NUM_CPU = 2;

  typedef struct packed {
    logic [1:0]  op;   // 0 write, 1 read, 2 drive lines, 3 check irq_out
    logic        cpu;
    logic [7:0]  addr;
    logic [31:0] data;
    logic [31:0] exp;
  } vec_t;

  localparam int NV = 45;
  localparam vec_t VEC [NV] = '{
    '{2'd1, 1'b0, 8'h00, 32'h0,    32'h0},      // R1 empty event
    '{2'd1, 1'b0, 8'h08, 32'h0,    32'hFFFF},   // R1 all masked
    '{2'd3, 1'b0, 8'h00, 32'h0,    32'h0},      // R1 outputs low
    '{2'd2, 1'b0, 8'h00, 32'h30,   32'h0},
    '{2'd3, 1'b0, 8'h00, 32'h0,    32'h0},      // R2 masked lines silent
    '{2'd0, 1'b0, 8'h09, 32'h30,   32'h0},
    '{2'd3, 1'b0, 8'h00, 32'h0,    32'h3},      // R2 both CPUs raised
    '{2'd1, 1'b0, 8'h00, 32'h0,    32'h10004},  // R4 lowest first
    '{2'd1, 1'b0, 8'h08, 32'h0,    32'hFFDF},   // R5 line 4 masked
    '{2'd1, 1'b1, 8'h00, 32'h0,    32'h10005},  // R5 other CPU sees 5
    '{2'd1, 1'b0, 8'h00, 32'h0,    32'h0},      // R6 empty read
    '{2'd1, 1'b0, 8'h08, 32'h0,    32'hFFFF},   // R6 no side effect
    '{2'd3, 1'b0, 8'h00, 32'h0,    32'h0},      // R2
    '{2'd0, 1'b0, 8'h0A, 32'h100,  32'h0},
    '{2'd0, 1'b0, 8'h48, 32'h2,    32'h0},
    '{2'd0, 1'b0, 8'h09, 32'h100,  32'h0},
    '{2'd3, 1'b0, 8'h00, 32'h0,    32'h2},      // R7 only CPU1
    '{2'd1, 1'b0, 8'h00, 32'h0,    32'h0},      // R7 CPU0 sees nothing
    '{2'd1, 1'b1, 8'h00, 32'h0,    32'h10008},  // R7 CPU1 gets 8
    '{2'd1, 1'b0, 8'h0A, 32'h0,    32'h100},    // R3 trigger kept
    '{2'd0, 1'b0, 8'h09, 32'h10,   32'h0},
    '{2'd3, 1'b0, 8'h00, 32'h0,    32'h3},      // R3 level kept
    '{2'd1, 1'b1, 8'h00, 32'h0,    32'h10004},  // R3
    '{2'd0, 1'b0, 8'h02, 32'h2,    32'h0},
    '{2'd3, 1'b0, 8'h00, 32'h0,    32'h2},      // R8 sent to CPU1
    '{2'd1, 1'b0, 8'h00, 32'h0,    32'h0},      // R8 not on sender
    '{2'd1, 1'b0, 8'h90, 32'h0,    32'h20001},  // R10 explicit view
    '{2'd3, 1'b0, 8'h00, 32'h0,    32'h0},      // R8 cleared
    '{2'd0, 1'b0, 8'h02, 32'h2,    32'h0},
    '{2'd3, 1'b0, 8'h00, 32'h0,    32'h0},      // R8 masked resend
    '{2'd1, 1'b0, 8'h93, 32'h0,    32'h22},     // R10 R8 pend+mask
    '{2'd0, 1'b1, 8'h04, 32'h2,    32'h0},
    '{2'd3, 1'b0, 8'h00, 32'h0,    32'h2},      // R8 rearmed
    '{2'd0, 1'b0, 8'h01, 32'h1,    32'h0},
    '{2'd3, 1'b0, 8'h00, 32'h0,    32'h3},      // R9 self IPI
    '{2'd1, 1'b0, 8'h00, 32'h0,    32'h20000},  // R9
    '{2'd1, 1'b1, 8'h00, 32'h0,    32'h20001},  // R8
    '{2'd0, 1'b0, 8'h04, 32'h1,    32'h0},
    '{2'd0, 1'b0, 8'h01, 32'h1,    32'h0},
    '{2'd2, 1'b0, 8'h00, 32'h38,   32'h0},
    '{2'd0, 1'b0, 8'h09, 32'h8,    32'h0},
    '{2'd1, 1'b0, 8'h00, 32'h0,    32'h10003},  // R4 line before IPI
    '{2'd1, 1'b0, 8'h00, 32'h0,    32'h20000},  // R4 then IPI
    '{2'd1, 1'b0, 8'h00, 32'h0,    32'h0},      // R6
    '{2'd1, 1'b0, 8'h48, 32'h0,    32'h2}       // R7 routing readback
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NUM_IRQ-1:0] hw_irq = '0;
  logic cpu_id = 1'b0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [NUM_CPU-1:0] irq_out;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  prio_irq_ctrl i_prio_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .hw_irq(hw_irq), .cpu_id(cpu_id),
    .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .irq_out(irq_out)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic c, input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    cpu_id = c; addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic c, input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    cpu_id = c; addr = a; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic out_after(output logic [31:0] d);
    @(posedge clk);
    @(negedge clk);
    d = 32'(irq_out);
  endtask

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check("R1 irq_out at reset", 32'(irq_out), 32'h0);
    for (int k = 0; k < NV; k++) begin
      case (VEC[k].op)
        2'd0: wr(VEC[k].cpu, VEC[k].addr, VEC[k].data);
        2'd1: begin
          rd(VEC[k].cpu, VEC[k].addr, v);
          check($sformatf("vector %0d read", k), v, VEC[k].exp);
        end
        2'd2: begin @(negedge clk); hw_irq = VEC[k].data[NUM_IRQ-1:0]; end
        default: begin
          out_after(v);
          check($sformatf("vector %0d irq_out", k), v, VEC[k].exp);
        end
      endcase
    end

    // R1 reset mid-run restores defaults
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    check("R1 irq_out in reset", 32'(irq_out), 32'h0);
    rst_n = 1'b1; hw_irq = '0;
    rd(1'b0, 8'h08, v); check("R1 mask after reset", v, 32'hFFFF);
    rd(1'b0, 8'h0A, v); check("R1 trigger after reset", v, 32'h0);
    rd(1'b0, 8'h03, v); check("R1 IPI state after reset", v, 32'h0);

    // R2 one-cycle latency, rise and fall
    @(negedge clk); hw_irq = 16'h0001;
    wr(1'b0, 8'h09, 32'h1);
    check("R2 not yet raised", 32'(irq_out), 32'h0);
    out_after(v); check("R2 raised one cycle later", v, 32'h3);
    @(negedge clk); hw_irq = '0;
    check("R2 still high at drop", 32'(irq_out), 32'h3);
    out_after(v); check("R2 falls with line", v, 32'h0);

    // R3 mask set disables a pending line
    @(negedge clk); hw_irq = 16'h0002;
    wr(1'b0, 8'h09, 32'h2);
    out_after(v); check("R3 line 1 raised", v, 32'h3);
    wr(1'b0, 8'h08, 32'h2);
    out_after(v); check("R3 mask set silences", v, 32'h0);
    rd(1'b1, 8'h00, v); check("R3 masked line not reported", v, 32'h0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule